// File: doc/BRIEF.md
# Keypad Code Lock Controller

The block scans a 4x4 matrix keypad whose keys pull a column line low, filters each press, and gathers up to four hex digits into an entry register. A clear key empties the entry. A store key saves a full four-digit entry as the lock code and locks. An open key unlocks only when the entry matches the saved code. The entry is also shown on four time-multiplexed seven-segment digits. The block drives the digit value; an external decoder turns it into segments.

One 4-bit scan counter drives both the row outputs and the column selection. The counter stops while the addressed key is held, so when the press is accepted the counter value is the key code. All logic runs on the system clock. A one-cycle `scan_tick` enable paces the scan and the debounce.

Top module: `keylock_ctrl`

## Requirements
- R1: Scan count bits [3:2] pick the row driven low: values 0, 1, 2 and 3 give `row_n` = 1110, 1101, 1011 and 0111. Bits [1:0] pick which `col_n` line is sampled. After reset the count is 0, so `row_n` = 1110. With no key down, all four row patterns appear over 16 ticks.
- R2: The scan count advances by one on a clock with `scan_tick` high, and only when the sampled column reads 1. While a key is held, the scan count stops on that key's code and the row pattern stays constant.
- R3: A 6-bit debounce counter reloads to 63 while the sampled column is high. It counts down on each tick while the column is low and stops at 1. A key is accepted once, as a one-cycle pulse, when the counter reaches 2, which is 61 ticks of continuous low. A press of about 30 ticks has no effect.
- R4: An accepted key with code 0 to 12 shifts its 4-bit code into a 16-bit entry from the right (entry = {entry[11:0], code}) and increments the digit count.
- R5: When four digits have already been taken, further digit keys leave the entry unchanged.
- R6: Key code 13 clears the entry to 0000 and the digit count to zero.
- R7: Key code 14, with four digits entered, copies the entry into the stored code and locks (`unlocked` = 0). With fewer than four digits entered, it changes nothing.
- R8: Key code 15, with four digits entered, sets `unlocked` = 1 only if the entry equals the stored code. A mismatch leaves `unlocked` unchanged.
- R9: A free-running counter steps the display every clock. `dig_en_n` = 0111, 1011, 1101 and 1110 show entry nibbles [15:12], [11:8], [7:4] and [3:0] on `dig_val`.
- R10: Reset leaves the block locked, with a stored code of 0000, an empty entry and a digit count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | One-cycle scan/debounce enable (about 1 kHz) |
| col_n | input | 4 | Keypad column lines, low when the addressed key is pressed |
| row_n | output | 4 | Keypad row drive, one line low |
| unlocked | output | 1 | Lock released |
| dig_en_n | output | 4 | Display digit enables, active low |
| dig_val | output | 4 | Hex value of the enabled digit |

## Verification
A key is accepted at most 16 ticks after it is pressed (the scan reaching it) plus 61 ticks (the debounce). The entry, stored code and unlock flag change one clock after that acceptance. The bench holds each key for 100 ticks and then waits 24 ticks after release before it samples anything. Display values are sampled on falling edges over eight clocks, which covers two full rounds of the digit enables, so the check does not depend on the display phase. The row freeze is observed only after the acceptance window has passed.

// File: rtl/keylock_ctrl.sv
module keylock_ctrl #(
  parameter int DB_W    = 6,
  parameter int DB_FIRE = 2,
  parameter int DISP_W  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_tick,
  input  logic [3:0] col_n,
  output logic [3:0] row_n,
  output logic       unlocked,
  output logic [3:0] dig_en_n,
  output logic [3:0] dig_val
);
  localparam logic [DB_W-1:0] DB_TOP  = {DB_W{1'b1}};
  localparam logic [DB_W-1:0] DB_HIT  = DB_W'(DB_FIRE);
  localparam logic [DB_W-1:0] DB_REST = DB_W'(1);
  localparam logic [3:0] K_CLR   = 4'd13;
  localparam logic [3:0] K_STORE = 4'd14;
  localparam logic [3:0] K_OPEN  = 4'd15;

  logic [3:0]        scan_cnt;
  logic [DB_W-1:0]   db_cnt;
  logic              fire_q;
  logic [15:0]       entry, stored;
  logic [2:0]        n_dig;
  logic [DISP_W-1:0] disp_cnt;

  wire col_bit = col_n[scan_cnt[1:0]];
  wire fire    = (db_cnt == DB_HIT);
  wire key_hit = fire & ~fire_q;
  wire full    = (n_dig == 3'd4);

  assign row_n = ~(4'b0001 << scan_cnt[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n)                 scan_cnt <= '0;
    else if (scan_tick && col_bit) scan_cnt <= scan_cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || col_bit)                   db_cnt <= DB_TOP;
    else if (scan_tick && db_cnt != DB_REST) db_cnt <= db_cnt - DB_REST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry    <= '0;
      stored   <= '0;
      n_dig    <= '0;
      unlocked <= 1'b0;
    end else if (key_hit) begin
      if (scan_cnt == K_CLR) begin
        entry <= '0;
        n_dig <= '0;
      end else if (scan_cnt < K_CLR) begin
        if (!full) begin
          entry <= {entry[11:0], scan_cnt};
          n_dig <= n_dig + 3'd1;
        end
      end else if (scan_cnt == K_STORE) begin
        if (full) begin
          stored   <= entry;
          unlocked <= 1'b0;
        end
      end else if (scan_cnt == K_OPEN) begin
        if (full && entry == stored) unlocked <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) disp_cnt <= '0;
    else        disp_cnt <= disp_cnt + DISP_W'(1);
  end

  wire [1:0] sel = disp_cnt[1:0];
  assign dig_en_n = ~(4'b1000 >> sel);
  assign dig_val  = entry[{2'(2'd3 - sel), 2'b00} +: 4];

  assert_scan_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !col_bit |=> $stable(scan_cnt));

  assert_hit_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> !key_hit);

  assert_hit_line_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |-> !col_bit);

  assert_count_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    n_dig <= 3'd4);

  assert_open_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(entry == stored && full));

  assert_en_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) == 1);
endmodule

// File: tb/keylock_ctrl_tb.sv
module keylock_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_tick = 1'b0;
  logic [3:0] col_n, row_n, dig_en_n, dig_val;
  logic unlocked;
  logic key_dn = 1'b0;
  logic [3:0] key_k = 4'd0;
  int checks = 0, failures = 0;
  logic [3:0] tdiv = 4'd0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == 4'd3) ? 4'd0 : tdiv + 4'd1;
    scan_tick <= (tdiv == 4'd3);
  end

  assign col_n = (key_dn && row_n == ~(4'b0001 << key_k[3:2])) ?
                 ~(4'b0001 << key_k[1:0]) : 4'hF;

  keylock_ctrl dut_i (.clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .col_n(col_n),
                      .row_n(row_n), .unlocked(unlocked), .dig_en_n(dig_en_n), .dig_val(dig_val));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] k, input int hold);
    key_k = k; key_dn = 1'b1;
    ticks(hold);
    key_dn = 1'b0;
    ticks(24);
  endtask

  task automatic check_disp(input logic [15:0] exp, input string req);
    logic [15:0] seen = 16'h0;
    repeat (8) begin
      @(negedge clk);
      case (dig_en_n)
        4'b0111: seen[15:12] = dig_val;
        4'b1011: seen[11:8]  = dig_val;
        4'b1101: seen[7:4]   = dig_val;
        4'b1110: seen[3:0]   = dig_val;
        default: seen = 16'hxxxx;
      endcase
    end
    check(seen === exp, req, 32'(seen), 32'(exp));
  endtask

  task automatic t_reset();
    check(row_n == 4'b1110, "R1 reset row", 32'(row_n), 32'hE);
    check(unlocked == 1'b0, "R10 reset locked", 32'(unlocked), 32'h0);
    check_disp(16'h0000, "R10 R9 reset entry");
  endtask

  task automatic t_scan();
    logic [3:0] seen_rows = 4'b0;
    bit bad = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      case (row_n)
        4'b1110: seen_rows[0] = 1'b1;
        4'b1101: seen_rows[1] = 1'b1;
        4'b1011: seen_rows[2] = 1'b1;
        4'b0111: seen_rows[3] = 1'b1;
        default: bad = 1'b1;
      endcase
    end
    check(!bad && seen_rows == 4'hF, "R1 row sweep", 32'(seen_rows), 32'hF);
  endtask

  task automatic t_reset_code();
    for (int i = 0; i < 4; i++) press(4'd0, 100);
    press(4'd15, 100);
    check(unlocked == 1'b1, "R10 R8 default code opens", 32'(unlocked), 32'h1);
  endtask

  task automatic t_entry();
    press(4'd13, 100);
    check_disp(16'h0000, "R6 clear");
    press(4'd1, 100); press(4'd2, 100); press(4'd3, 100); press(4'd4, 100);
    check_disp(16'h1234, "R4 R9 digits shift in");
    press(4'd9, 100);
    check_disp(16'h1234, "R5 fifth digit ignored");
    press(4'd14, 100);
    check(unlocked == 1'b0, "R7 store locks", 32'(unlocked), 32'h0);
    press(4'd13, 100);
    check_disp(16'h0000, "R6 clear after store");
  endtask

  task automatic t_wrong();
    press(4'd1, 100); press(4'd2, 100); press(4'd3, 100); press(4'd5, 100);
    press(4'd15, 100);
    check(unlocked == 1'b0, "R8 wrong code rejected", 32'(unlocked), 32'h0);
    press(4'd13, 100);
  endtask

  task automatic t_freeze();
    logic [3:0] r0;
    key_k = 4'd10; key_dn = 1'b1;
    ticks(90);
    r0 = row_n;
    check(r0 == 4'b1011, "R2 row held on key", 32'(r0), 32'hB);
    ticks(20);
    check(row_n == r0, "R2 row stays frozen", 32'(row_n), 32'(r0));
    key_dn = 1'b0;
    ticks(24);
    check_disp(16'h000A, "R2 R4 held key accepted once");
    press(4'd13, 100);
  endtask

  task automatic t_short();
    press(4'd7, 30);
    check_disp(16'h0000, "R3 short press ignored");
  endtask

  task automatic t_partial_store();
    press(4'd5, 100);
    press(4'd14, 100);
    press(4'd13, 100);
    press(4'd1, 100); press(4'd2, 100); press(4'd3, 100); press(4'd4, 100);
    press(4'd15, 100);
    check(unlocked == 1'b1, "R7 R8 partial store ignored, right code opens", 32'(unlocked), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan();
    t_reset_code();
    t_entry();
    t_wrong();
    t_freeze();
    t_short();
    t_partial_store();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule